// File: doc/BRIEF.md
# Road-Based Track Linker

The linker turns per-layer segment hits from one phi slice into track candidates. Each of four layers presents a bitmap of fired pixels and, for every pixel, a slope code. A loadable table of roads lists the valid four-layer combinations. Each road names one pixel and one slope code per layer, and carries a momentum code, a phi code and an enable bit. A road matches only when, in all four layers, its pixel has fired and the slope code at that pixel equals the road's slope code.

An evaluation is started by a one-cycle `start` pulse, which samples the hit and slope inputs. The matching roads are then streamed out one per cycle in ascending road index order, each beat carrying the road's momentum and phi codes. The stream is capped at a parameterised number of tracks per slice. A last flag closes every evaluation, and an overflow flag reports matches that did not fit. The table can be rewritten between evaluations, for example when the beam position moves.

Top module: `road_track_linker`

## Requirements
- R1: A load (ld_en high while not busy) writes entry ld_idx. Reset clears every road's enable bit, so no road matches until one is loaded with ld_enable=1.
- R2: An enabled road matches when, in each layer l (0..3), input bit hits[l*NUM_PIX+p] is 1 for the road's pixel p, and slopes[(l*NUM_PIX+p)*SLW +: SLW] equals the road's slope code for that layer. ld_pix holds layer l at [l*PIXW +: PIXW] and ld_slope holds layer l at [l*SLW +: SLW].
- R3: A road whose pixel is not fired in any one layer never matches, even when the slope code at that pixel agrees.
- R4: Layers 0 and 1 use slope codes 0..INNER_BINS-1 (0..2), and layers 2 and 3 use 0..OUTER_BINS-1 (0..4). A road holding a code outside its layer's range never matches.
- R5: A road whose momentum code is below PT_MIN (default 2) never matches.
- R6: Matched roads are emitted one per cycle in ascending road index order. The first beat appears in the cycle after the start edge, and at most MAX_TRK (default 3) valid beats are emitted per evaluation.
- R7: trk_last is high on the final beat of every evaluation, and busy falls after it. An evaluation with no match emits exactly one beat, with trk_last high and trk_valid low.
- R8: trk_ovf is high, together with trk_last and trk_valid, exactly when more roads matched than were emitted.
- R9: start and ld_en are ignored while busy. The running stream is unchanged, and the table keeps its old contents.
- R10: When not busy, trk_valid, trk_last and trk_ovf are low. After reset, busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_en | input | 1 | Write one road entry |
| ld_idx | input | RIW | Road index to write |
| ld_enable | input | 1 | Enable bit of the written road |
| ld_pix | input | 4*PIXW | Pixel index per layer |
| ld_slope | input | 4*SLW | Slope code per layer |
| ld_pt | input | PT_W | Momentum code |
| ld_phi | input | PHI_W | Phi code |
| start | input | 1 | Start an evaluation, sampling hits and slopes |
| hits | input | 4*NUM_PIX | Fired-pixel bitmap, layer-major |
| slopes | input | 4*NUM_PIX*SLW | Slope code per pixel, layer-major |
| busy | output | 1 | Evaluation stream in progress |
| trk_valid | output | 1 | Beat carries a track |
| trk_last | output | 1 | Final beat of the evaluation |
| trk_ovf | output | 1 | Matches were dropped by the cap |
| trk_pt | output | PT_W | Momentum code of the track |
| trk_phi | output | PHI_W | Phi code of the track |

## Verification
The assertions treat `start` as meaningful only when the block is idle, and they check the stream shape rather than the match content. The properties covered are the beat cap, last ending the stream, overflow only on a valid last beat, and quiet outputs while idle. They assume that ld_idx stays below NUM_ROADS and that reset is applied before use. The stimulus only writes in-range indices, holds reset for several cycles at the start, and deliberately raises start and ld_en during a running stream to confirm that both are ignored.

// File: rtl/road_track_linker.sv
module road_track_linker #(
  parameter int NUM_PIX    = 12,
  parameter int NUM_ROADS  = 16,
  parameter int MAX_TRK    = 3,
  parameter int SLW        = 3,
  parameter int INNER_BINS = 3,
  parameter int OUTER_BINS = 5,
  parameter int PT_W       = 5,
  parameter int PHI_W      = 6,
  parameter int PT_MIN     = 2,
  localparam int PIXW = $clog2(NUM_PIX),
  localparam int RIW  = $clog2(NUM_ROADS),
  localparam int CW   = $clog2(MAX_TRK + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [RIW-1:0]           ld_idx,
  input  logic                     ld_enable,
  input  logic [4*PIXW-1:0]        ld_pix,
  input  logic [4*SLW-1:0]         ld_slope,
  input  logic [PT_W-1:0]          ld_pt,
  input  logic [PHI_W-1:0]         ld_phi,
  input  logic                     start,
  input  logic [4*NUM_PIX-1:0]     hits,
  input  logic [4*NUM_PIX*SLW-1:0] slopes,
  output logic                     busy,
  output logic                     trk_valid,
  output logic                     trk_last,
  output logic                     trk_ovf,
  output logic [PT_W-1:0]          trk_pt,
  output logic [PHI_W-1:0]         trk_phi
);

  logic                r_en  [NUM_ROADS];
  logic [4*PIXW-1:0]   r_pix [NUM_ROADS];
  logic [4*SLW-1:0]    r_slo [NUM_ROADS];
  logic [PT_W-1:0]     r_pt  [NUM_ROADS];
  logic [PHI_W-1:0]    r_phi [NUM_ROADS];

  logic [NUM_ROADS-1:0] match, pend, rest;
  logic [RIW-1:0]       first;
  logic [CW-1:0]        cnt;

  wire wr = ld_en && !busy && (int'(ld_idx) < NUM_ROADS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ROADS; r++) r_en[r] <= 1'b0;
    end else if (wr) begin
      r_en[ld_idx] <= ld_enable;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) begin
      r_pix[ld_idx] <= ld_pix;
      r_slo[ld_idx] <= ld_slope;
      r_pt[ld_idx]  <= ld_pt;
      r_phi[ld_idx] <= ld_phi;
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_ROADS; r++) begin
      logic ok;
      ok = r_en[r] && (int'(r_pt[r]) >= PT_MIN);
      for (int l = 0; l < 4; l++) begin
        logic [PIXW-1:0] pv;
        logic [SLW-1:0]  sv;
        int              p;
        pv = r_pix[r][l*PIXW +: PIXW];
        sv = r_slo[r][l*SLW +: SLW];
        p  = int'(pv);
        if (p >= NUM_PIX)
          ok = 1'b0;
        else if (int'(sv) >= ((l < 2) ? INNER_BINS : OUTER_BINS))
          ok = 1'b0;
        else if (!hits[l*NUM_PIX + p] || (slopes[(l*NUM_PIX + p)*SLW +: SLW] != sv))
          ok = 1'b0;
      end
      match[r] = ok;
    end
  end

  always_comb begin
    first = '0;
    for (int i = NUM_ROADS - 1; i >= 0; i--)
      if (pend[i]) first = RIW'(i);
  end

  assign rest      = pend & (pend - NUM_ROADS'(1));
  assign trk_last  = busy && ((rest == '0) || (cnt == CW'(MAX_TRK - 1)));
  assign trk_valid = busy && (pend != '0);
  assign trk_ovf   = trk_last && trk_valid && (rest != '0);
  assign trk_pt    = trk_valid ? r_pt[first]  : '0;
  assign trk_phi   = trk_valid ? r_phi[first] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= '0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        pend <= match;
        cnt  <= '0;
      end
    end else begin
      pend <= rest;
      cnt  <= cnt + CW'(1);
      if (trk_last) busy <= 1'b0;
    end
  end

endmodule

module road_track_linker_chk #(
  parameter int MAX_TRK = 3
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic trk_valid,
  input logic trk_last,
  input logic trk_ovf
);

  int vc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vc <= 0;
    else if (trk_last) vc <= 0;
    else if (trk_valid) vc <= vc + 1;
  end

  a_r6_max_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    trk_valid |-> (vc < MAX_TRK));

  a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    trk_last |=> !busy);

  a_r8_ovf_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    trk_ovf |-> (trk_last && trk_valid));

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !trk_last) |=> busy);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!trk_valid && !trk_last && !trk_ovf));

endmodule

bind road_track_linker road_track_linker_chk #(.MAX_TRK(MAX_TRK)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .trk_valid(trk_valid),
  .trk_last(trk_last), .trk_ovf(trk_ovf)
);

// File: tb/tb_road_track_linker.sv
module tb_road_track_linker;
  localparam int NP = 12, NR = 16, SLW = 3, PIXW = 4, RIW = 4;

  logic clk = 0, rst_n = 0;
  logic ld_en = 0, ld_enable = 0, start = 0;
  logic [RIW-1:0] ld_idx = '0;
  logic [4*PIXW-1:0] ld_pix = '0;
  logic [4*SLW-1:0] ld_slope = '0;
  logic [4:0] ld_pt = '0;
  logic [5:0] ld_phi = '0;
  logic [4*NP-1:0] hits = '0;
  logic [4*NP*SLW-1:0] slopes = '0;
  logic busy, trk_valid, trk_last, trk_ovf;
  logic [4:0] trk_pt;
  logic [5:0] trk_phi;

  road_track_linker dut (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  logic [4*NP-1:0] hitv;
  logic [4*NP*SLW-1:0] slov;
  int nb;
  int gv[10], gl[10], gov[10], gpt[10], gphi[10];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load(input int idx, input bit en, input int p[4], input int s[4], input int pt, input int phi);
    @(negedge clk);
    ld_en = 1; ld_idx = RIW'(idx); ld_enable = en; ld_pt = 5'(pt); ld_phi = 6'(phi);
    for (int l = 0; l < 4; l++) begin
      ld_pix[l*PIXW +: PIXW] = PIXW'(p[l]);
      ld_slope[l*SLW +: SLW] = SLW'(s[l]);
    end
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic clear_hits();
    hitv = '0; slov = '0;
  endtask

  task automatic fire(input int l, input int p, input int s);
    hitv[l*NP + p] = 1'b1;
    slov[(l*NP + p)*SLW +: SLW] = SLW'(s);
  endtask

  task automatic fire_road(input int p[4], input int s[4]);
    for (int l = 0; l < 4; l++) fire(l, p[l], s[l]);
  endtask

  task automatic eval(input int disturb);
    @(negedge clk);
    start = 1; hits = hitv; slopes = slov;
    @(negedge clk);
    start = 0;
    nb = 0;
    for (int k = 0; k < 10; k++) begin
      gv[nb] = trk_valid; gl[nb] = trk_last; gov[nb] = trk_ovf;
      gpt[nb] = int'(trk_pt); gphi[nb] = int'(trk_phi);
      nb++;
      if (trk_last) break;
      if (k == 0 && disturb == 1) begin
        ld_en = 1; ld_idx = 4'd9; ld_enable = 1; ld_pt = 5'd31; ld_phi = 6'd1;
      end
      if (k == 0 && disturb == 2) begin
        start = 1; hits = '1; slopes = '0;
      end
      @(negedge clk);
      ld_en = 0; start = 0;
    end
    ld_en = 0; start = 0;
  endtask

  task automatic expect_empty(input string req);
    chk(nb == 1, req, "empty beats", nb, 1);
    chk(gv[0] == 0 && gl[0] == 1, req, "empty beat valid/last", gv[0]*2 + gl[0], 1);
  endtask

  task automatic expect_beat(input int i, input int pt, input int phi, input bit last, input bit ovf, input string req);
    chk(gv[i] == 1, req, $sformatf("beat %0d valid", i), gv[i], 1);
    chk(gpt[i] == pt && gphi[i] == phi, req, $sformatf("beat %0d pt*64+phi", i), gpt[i]*64 + gphi[i], pt*64 + phi);
    chk(gl[i] == int'(last) && gov[i] == int'(ovf), req, $sformatf("beat %0d last*2+ovf", i), gl[i]*2 + gov[i], int'(last)*2 + int'(ovf));
  endtask

  task automatic t_reset();
    chk(busy == 0 && trk_valid == 0 && trk_last == 0 && trk_ovf == 0, "R10", "idle outputs after reset",
        {busy, trk_valid, trk_last, trk_ovf}, 0);
    hitv = '1; slov = '0;
    eval(0);
    expect_empty("R1");
  endtask

  task automatic t_single();
    load(5, 1, '{3,4,6,7}, '{1,2,4,0}, 10, 33);
    clear_hits(); fire_road('{3,4,6,7}, '{1,2,4,0});
    eval(0);
    chk(nb == 1, "R2", "single match beats", nb, 1);
    expect_beat(0, 10, 33, 1, 0, "R2");
    @(negedge clk);
    chk(busy == 0, "R7", "busy after last", busy, 0);
  endtask

  task automatic t_slope_miss();
    clear_hits(); fire_road('{3,4,6,7}, '{1,2,4,1});
    eval(0);
    expect_empty("R2");
  endtask

  task automatic t_pixel_miss();
    clear_hits();
    fire(0,3,1); fire(1,4,2); fire(2,6,4);
    slov[(3*NP + 7)*SLW +: SLW] = 3'd0;
    eval(0);
    expect_empty("R3");
  endtask

  task automatic t_disabled();
    load(5, 0, '{3,4,6,7}, '{1,2,4,0}, 10, 33);
    clear_hits(); fire_road('{3,4,6,7}, '{1,2,4,0});
    eval(0);
    expect_empty("R1");
    load(5, 1, '{3,4,6,7}, '{1,2,4,0}, 10, 33);
  endtask

  task automatic t_slope_range();
    load(7, 1, '{9,9,9,9}, '{3,0,0,0}, 9, 20);
    clear_hits(); fire_road('{9,9,9,9}, '{3,0,0,0});
    eval(0);
    expect_empty("R4");
    load(8, 1, '{10,10,10,10}, '{0,0,5,0}, 9, 21);
    clear_hits(); fire_road('{10,10,10,10}, '{0,0,5,0});
    eval(0);
    expect_empty("R4");
  endtask

  task automatic t_threshold();
    load(6, 1, '{11,11,11,11}, '{0,0,0,0}, 1, 22);
    clear_hits(); fire_road('{11,11,11,11}, '{0,0,0,0});
    eval(0);
    expect_empty("R5");
    load(6, 1, '{11,11,11,11}, '{0,0,0,0}, 2, 22);
    eval(0);
    chk(nb == 1, "R5", "threshold match beats", nb, 1);
    expect_beat(0, 2, 22, 1, 0, "R5");
    load(6, 0, '{11,11,11,11}, '{0,0,0,0}, 2, 22);
  endtask

  task automatic fire_three();
    clear_hits();
    fire_road('{1,1,1,1}, '{0,0,0,0});
    fire_road('{2,2,2,2}, '{1,1,1,1});
    fire_road('{5,5,5,5}, '{2,2,3,3});
  endtask

  task automatic t_order();
    load(12, 1, '{5,5,5,5}, '{2,2,3,3}, 5, 12);
    load(9,  1, '{2,2,2,2}, '{1,1,1,1}, 4, 11);
    load(2,  1, '{1,1,1,1}, '{0,0,0,0}, 3, 10);
    fire_three();
    eval(0);
    chk(nb == 3, "R6", "ordered beats", nb, 3);
    expect_beat(0, 3, 10, 0, 0, "R6");
    expect_beat(1, 4, 11, 0, 0, "R6");
    expect_beat(2, 5, 12, 1, 0, "R7");
  endtask

  task automatic t_overflow();
    load(1, 1, '{8,8,8,8}, '{0,1,2,4}, 6, 13);
    fire_three(); fire_road('{8,8,8,8}, '{0,1,2,4});
    eval(0);
    chk(nb == 3, "R6", "capped beats", nb, 3);
    expect_beat(0, 6, 13, 0, 0, "R6");
    expect_beat(1, 3, 10, 0, 0, "R6");
    expect_beat(2, 4, 11, 1, 1, "R8");
    load(1, 0, '{8,8,8,8}, '{0,1,2,4}, 6, 13);
  endtask

  task automatic t_busy_load();
    fire_three();
    eval(1);
    chk(nb == 3, "R9", "beats with load while busy", nb, 3);
    expect_beat(1, 4, 11, 0, 0, "R9");
    eval(0);
    expect_beat(1, 4, 11, 0, 0, "R9");
  endtask

  task automatic t_busy_start();
    fire_three();
    eval(2);
    chk(nb == 3, "R9", "beats with start while busy", nb, 3);
    expect_beat(2, 5, 12, 1, 0, "R9");
    @(negedge clk);
    chk(busy == 0 && trk_valid == 0 && trk_last == 0, "R10", "idle after stream",
        {busy, trk_valid, trk_last}, 0);
  endtask

  task automatic t_reload();
    load(9, 1, '{2,2,2,2}, '{1,1,1,1}, 7, 44);
    fire_three();
    eval(0);
    expect_beat(1, 7, 44, 0, 0, "R1");
  endtask

  initial begin
    clear_hits();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_slope_miss();
    t_pixel_miss();
    t_disabled();
    t_slope_range();
    t_threshold();
    t_order();
    t_overflow();
    t_busy_load();
    t_busy_start();
    t_reload();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule